// File: doc/BRIEF.md
# Character LCD Bus Cycle Generator

This block sits on the host side of a parallel character-display bus and runs one read or one write cycle per command. The bus carries a register-select line, a direction line (high means read), an enable strobe and an 8-bit data bus. A command presents the select bit, the direction and, for writes, a data byte. The engine holds the address lines, raises the strobe, drops it and keeps the lines steady afterwards. Each phase lasts a whole number of system clock cycles.

Every phase length is worked out at elaboration from nanosecond parameters and a clock-period parameter, as ceiling(ns / period). The strobe edge time is added to each window as margin. The data bus is modelled as separate output, output-enable and input vectors, so the pad tristate lives outside the block. On a read the returned byte is captured while the strobe is still high. The capture point is picked by a parameter: the falling strobe edge, or the earliest cycle at which the display is guaranteed to drive valid data. A one-cycle done pulse follows the strobe's fall in both directions.

With the default parameters (10 ns clock, 40 ns address setup, 230 ns pulse, 120 ns read delay, 60 ns write setup, 10 ns holds, 25 ns edges, 500 ns cycle) the phases are: setup 7 cycles, strobe 26 cycles, early-capture point 15 cycles after the strobe rises, hold 17 cycles, and 50 busy cycles in total.

Top module: `charlcd_cycle_engine`

## Requirements
- R1: After reset, busy, the strobe, the data output enable and done are all low.
- R2: A command is taken on a clock edge where cmd_valid is high and busy is low. While busy is high, cmd_valid and the command fields have no effect on any bus output or on the cycle length.
- R3: On the edge that accepts a command, lcd_rs takes cmd_rs and lcd_rw takes cmd_read, and both stay unchanged until busy falls. The strobe stays low for N_SU = ceil((t_addr_setup + t_edge) / t_clk) cycles after acceptance (7 at defaults).
- R4: The strobe stays high for N_PW cycles. N_PW is the largest of ceil((t_pulse + t_edge)/t_clk), ceil((t_rd_delay + t_edge)/t_clk) + 1 and ceil((t_wr_setup + t_edge)/t_clk) (26 at defaults).
- R5: busy stays high for N_SU + N_PW + N_HD cycles. After the strobe falls, the hold phase N_HD is at least the larger of the address and write-data hold, each plus t_edge. It is stretched so the total is at least ceil(t_cycle / t_clk). At defaults N_HD = 17 and the total is 50.
- R6: In a write cycle, lcd_oe is high and lcd_dout equals the accepted write byte for every cycle in which busy is high. lcd_oe is low whenever busy is low.
- R7: In a read cycle, lcd_oe stays low for the whole cycle, including before the strobe rises.
- R8: With late capture (EARLY_CAPTURE = 0), rd_data takes the value lcd_din has on the clock edge that drops the strobe. done is high for exactly the one cycle after that edge.
- R9: A write cycle also produces the single done pulse after the strobe falls, and it leaves rd_data unchanged.
- R10: With early capture (EARLY_CAPTURE = 1), rd_data takes the value lcd_din has on the edge N_RD = ceil((t_rd_delay + t_edge)/t_clk) cycles after the strobe rises (15 at defaults). Later changes on lcd_din during the strobe do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_rs | input | 1 | Register-select value for the cycle |
| cmd_read | input | 1 | 1 = read cycle, 0 = write cycle |
| cmd_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | High from acceptance to end of hold; commands refused |
| done | output | 1 | One-cycle pulse after the strobe falls |
| rd_data | output | DATA_W | Last byte captured on a read |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus direction, high = read |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_dout | output | DATA_W | Data driven toward the display |
| lcd_oe | output | 1 | Output enable for the data pads |
| lcd_din | input | DATA_W | Data returned by the display |

## Verification
A phase counter loaded with a wrong value shows up directly at the pins. The strobe rises or falls one or more cycles off the counted position, or busy drops early. The bench sees this within the first command, because it times every strobe edge and the busy length against computed counts. A wrong capture point is exposed by a bus model that presents one byte at the early-capture cycle and a different one just after it. Each capture variant therefore returns a predictable, distinct byte, and a sampling error is caught on the first read. A wrongly held select, direction or enable line would change mid-cycle while junk commands are applied, and the per-cycle comparison catches it in that same cycle.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_t;

   function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/charlcd_phase_seq.sv
module charlcd_phase_seq
   import charlcd_pkg::*;
#(
   parameter int unsigned N_SU = 7,
   parameter int unsigned N_PW = 26,
   parameter int unsigned N_RD = 15,
   parameter int unsigned N_HD = 17,
   parameter int unsigned CW   = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   output logic accept,
   output logic busy,
   output logic strobe,
   output logic fall_evt,
   output logic early_evt,
   output logic end_evt
);

   localparam logic [CW-1:0] LD_SU    = CW'(N_SU - 1);
   localparam logic [CW-1:0] LD_PW    = CW'(N_PW - 1);
   localparam logic [CW-1:0] LD_HD    = CW'(N_HD - 1);
   localparam logic [CW-1:0] EARLY_AT = CW'(N_PW - N_RD);

   phase_t          ph_q;
   logic [CW-1:0]   cnt_q;
   logic            strobe_q;
   logic            last;

   assign last      = (cnt_q == '0);
   assign accept    = cmd_valid && (ph_q == PH_IDLE);
   assign busy      = (ph_q != PH_IDLE);
   assign strobe    = strobe_q;
   assign fall_evt  = (ph_q == PH_STROBE) && last;
   assign early_evt = (ph_q == PH_STROBE) && (cnt_q == EARLY_AT);
   assign end_evt   = (ph_q == PH_HOLD) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (accept) begin
                  ph_q  <= PH_SETUP;
                  cnt_q <= LD_SU;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  ph_q     <= PH_STROBE;
                  cnt_q    <= LD_PW;
                  strobe_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_STROBE: begin
               if (last) begin
                  ph_q     <= PH_HOLD;
                  cnt_q    <= LD_HD;
                  strobe_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (last) begin
                  ph_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   // R5: the strobe is only ever high inside a busy window
   p_strobe_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> busy);

   // R2: once a cycle is running, a second request does not restart it
   p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && !end_evt) |=> busy);

   // R8: the fall event is immediately followed by the strobe going low
   p_fall_drops_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> !strobe_q);

endmodule

// File: rtl/charlcd_pin_drv.sv
module charlcd_pin_drv #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              end_evt,
   input  logic              busy,
   input  logic              cmd_rs,
   input  logic              cmd_read,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              lcd_rs,
   output logic              lcd_rw,
   output logic              lcd_oe,
   output logic [DATA_W-1:0] lcd_dout
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcd_rs   <= 1'b0;
         lcd_rw   <= 1'b1;
         lcd_oe   <= 1'b0;
         lcd_dout <= '0;
      end else if (accept) begin
         lcd_rs   <= cmd_rs;
         lcd_rw   <= cmd_read;
         lcd_oe   <= !cmd_read;
         lcd_dout <= cmd_read ? '0 : cmd_wdata;
      end else if (end_evt) begin
         lcd_oe   <= 1'b0;
      end
   end

   // R3/R6: address and write data frozen for the whole busy window
   p_lines_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable({lcd_rs, lcd_rw, lcd_dout, lcd_oe}));

   // R7: the pads are never driven during a read cycle
   p_oe_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_oe |-> !lcd_rw);

   // R6: no drive outside a cycle
   p_oe_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !lcd_oe);

endmodule

// File: rtl/charlcd_rd_capture.sv
module charlcd_rd_capture #(
   parameter int unsigned DATA_W        = 8,
   parameter bit          EARLY_CAPTURE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_evt,
   input  logic              early_evt,
   input  logic              is_read,
   input  logic [DATA_W-1:0] lcd_din,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);

   logic take;

   generate
      if (EARLY_CAPTURE) begin : g_early
         assign take = early_evt && is_read;
      end else begin : g_late
         assign take = fall_evt && is_read;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         done    <= 1'b0;
      end else begin
         done <= fall_evt;
         if (take) begin
            rd_data <= lcd_din;
         end
      end
   end

   // R9: a write cycle never disturbs the read result
   p_write_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_read |=> $stable(rd_data));

endmodule

// File: rtl/charlcd_cycle_engine.sv
module charlcd_cycle_engine
   import charlcd_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned CLK_PERIOD_NS  = 10,
   parameter int unsigned T_ADDR_SU_NS   = 40,
   parameter int unsigned T_ADDR_HD_NS   = 10,
   parameter int unsigned T_PULSE_NS     = 230,
   parameter int unsigned T_CYCLE_NS     = 500,
   parameter int unsigned T_WR_SU_NS     = 60,
   parameter int unsigned T_WR_HD_NS     = 10,
   parameter int unsigned T_RD_DLY_NS    = 120,
   parameter int unsigned T_EDGE_NS      = 25,
   parameter bit          EARLY_CAPTURE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_rs,
   input  logic              cmd_read,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              lcd_rs,
   output logic              lcd_rw,
   output logic              lcd_e,
   output logic [DATA_W-1:0] lcd_dout,
   output logic              lcd_oe,
   input  logic [DATA_W-1:0] lcd_din
);

   localparam int unsigned N_SU  = umax(1, cdiv(T_ADDR_SU_NS + T_EDGE_NS, CLK_PERIOD_NS));
   localparam int unsigned N_RD  = umax(1, cdiv(T_RD_DLY_NS + T_EDGE_NS, CLK_PERIOD_NS));
   localparam int unsigned N_PW  = umax(umax(cdiv(T_PULSE_NS + T_EDGE_NS, CLK_PERIOD_NS), N_RD + 1),
                                        cdiv(T_WR_SU_NS + T_EDGE_NS, CLK_PERIOD_NS));
   localparam int unsigned N_HDB = umax(1, umax(cdiv(T_ADDR_HD_NS + T_EDGE_NS, CLK_PERIOD_NS),
                                                cdiv(T_WR_HD_NS + T_EDGE_NS, CLK_PERIOD_NS)));
   localparam int unsigned N_CYC = cdiv(T_CYCLE_NS, CLK_PERIOD_NS);
   localparam int unsigned N_HD  = (N_SU + N_PW + N_HDB >= N_CYC) ? N_HDB : (N_CYC - N_SU - N_PW);
   localparam int unsigned N_TOT = N_SU + N_PW + N_HD;
   localparam int unsigned CW    = $clog2(N_TOT + 1);
   localparam int unsigned MIN_SU = cdiv(T_ADDR_SU_NS, CLK_PERIOD_NS);
   localparam int unsigned MIN_PW = cdiv(T_PULSE_NS, CLK_PERIOD_NS);

   generate
      if (CLK_PERIOD_NS == 0) begin : g_bad_clk
         $error("CLK_PERIOD_NS must be non-zero");
      end
      if (DATA_W == 0) begin : g_bad_width
         $error("DATA_W must be non-zero");
      end
   endgenerate

   logic accept, fall_evt, early_evt, end_evt;

   charlcd_phase_seq #(
      .N_SU (N_SU),
      .N_PW (N_PW),
      .N_RD (N_RD),
      .N_HD (N_HD),
      .CW   (CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .accept    (accept),
      .busy      (busy),
      .strobe    (lcd_e),
      .fall_evt  (fall_evt),
      .early_evt (early_evt),
      .end_evt   (end_evt)
   );

   charlcd_pin_drv #(
      .DATA_W (DATA_W)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .end_evt   (end_evt),
      .busy      (busy),
      .cmd_rs    (cmd_rs),
      .cmd_read  (cmd_read),
      .cmd_wdata (cmd_wdata),
      .lcd_rs    (lcd_rs),
      .lcd_rw    (lcd_rw),
      .lcd_oe    (lcd_oe),
      .lcd_dout  (lcd_dout)
   );

   charlcd_rd_capture #(
      .DATA_W        (DATA_W),
      .EARLY_CAPTURE (EARLY_CAPTURE)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_evt  (fall_evt),
      .early_evt (early_evt),
      .is_read   (lcd_rw),
      .lcd_din   (lcd_din),
      .rd_data   (rd_data),
      .done      (done)
   );

   // Window checkers: independent cycle counters on the pins
   logic [CW-1:0] chk_hi_q, chk_su_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_hi_q <= '0;
         chk_su_q <= '0;
      end else begin
         chk_hi_q <= lcd_e ? chk_hi_q + 1'b1 : '0;
         chk_su_q <= (busy && !lcd_e) ? chk_su_q + 1'b1 : '0;
      end
   end

   // R3: address setup window before the strobe rises
   p_addr_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_e) |-> (chk_su_q >= CW'(MIN_SU)));

   // R4: minimum strobe width
   p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_e) |-> (chk_hi_q >= CW'(MIN_PW)));

   // R8: done marks the cycle right after the strobe falls
   p_done_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(lcd_e));

   // R1: reset state
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!busy && !lcd_e && !lcd_oe && !done));

endmodule

// File: tb/charlcd_cycle_engine_tb.sv
module charlcd_cycle_engine_tb;

   localparam int CLK_NS = 10;

   function automatic int cdiv(input int n, input int d);
      return (n + d - 1) / d;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_SU  = cdiv(40 + 25, CLK_NS);
   localparam int E_RD  = cdiv(120 + 25, CLK_NS);
   localparam int E_PW  = imax(imax(cdiv(230 + 25, CLK_NS), E_RD + 1), cdiv(60 + 25, CLK_NS));
   localparam int E_HDB = imax(cdiv(10 + 25, CLK_NS), cdiv(10 + 25, CLK_NS));
   localparam int E_CYC = cdiv(500, CLK_NS);
   localparam int E_HD  = (E_SU + E_PW + E_HDB >= E_CYC) ? E_HDB : E_CYC - E_SU - E_PW;
   localparam int E_TOT = E_SU + E_PW + E_HD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_rs = 1'b0, cmd_read = 1'b0;
   logic [7:0] cmd_wdata = '0;
   logic [7:0] lcd_din = '0;
   logic busy, done, lcd_rs, lcd_rw, lcd_e, lcd_oe;
   logic [7:0] rd_data, lcd_dout;
   logic busy_x, done_x, lcd_rs_x, lcd_rw_x, lcd_e_x, lcd_oe_x;
   logic [7:0] rd_data_x, lcd_dout_x;

   int n_chk = 0, n_bad = 0;
   logic [7:0] b1 = 8'h11;
   int hi_n = 0, post_n = 0;

   always #(CLK_NS/2) clk = ~clk;

   charlcd_cycle_engine #(.EARLY_CAPTURE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
      .cmd_read(cmd_read), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
      .rd_data(rd_data), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
      .lcd_dout(lcd_dout), .lcd_oe(lcd_oe), .lcd_din(lcd_din));

   charlcd_cycle_engine #(.EARLY_CAPTURE(1'b1)) u_dut_early (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
      .cmd_read(cmd_read), .cmd_wdata(cmd_wdata), .busy(busy_x), .done(done_x),
      .rd_data(rd_data_x), .lcd_rs(lcd_rs_x), .lcd_rw(lcd_rw_x), .lcd_e(lcd_e_x),
      .lcd_dout(lcd_dout_x), .lcd_oe(lcd_oe_x), .lcd_din(lcd_din));

   // Display model: junk, then byte b1 at the early point, then b1^5A until after the fall
   always @(negedge clk) begin
      if (lcd_e) begin
         hi_n   = hi_n + 1;
         post_n = 0;
         if (hi_n >= E_RD + 1)      lcd_din <= b1 ^ 8'h5A;
         else if (hi_n >= E_RD)     lcd_din <= b1;
         else                       lcd_din <= b1 ^ 8'hFF;
      end else begin
         hi_n   = 0;
         post_n = post_n + 1;
         if (post_n > 2) lcd_din <= b1 ^ 8'hFF;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one command; junk requests are applied during busy when noisy is set
   task automatic run_cmd(input bit rs, input bit rd, input logic [7:0] wd,
                          input logic [7:0] byte1, input bit noisy,
                          inout logic [7:0] exp_late, inout logic [7:0] exp_early);
      int idx, first_e, e_cnt, done_idx, done_cnt, busy_cnt;
      bit lines_ok, oe_ok, dout_ok;
      @(negedge clk);
      check(!busy && !busy_x, "R2 idle before command", busy, 0);
      b1 = byte1;
      cmd_valid = 1'b1; cmd_rs = rs; cmd_read = rd; cmd_wdata = wd;
      idx = 0; first_e = 0; e_cnt = 0; done_idx = 0; done_cnt = 0; busy_cnt = 0;
      lines_ok = 1'b1; oe_ok = 1'b1; dout_ok = 1'b1;
      forever begin
         @(negedge clk);
         idx++;
         if (!busy || idx > 200) break;
         busy_cnt++;
         if (lcd_e) begin
            e_cnt++;
            if (first_e == 0) first_e = idx;
         end
         if (done) begin done_cnt++; done_idx = idx; end
         if (lcd_rs != rs || lcd_rw != rd || lcd_rs_x != rs || lcd_rw_x != rd) lines_ok = 1'b0;
         if (lcd_oe != !rd) oe_ok = 1'b0;
         if (!rd && lcd_dout != wd) dout_ok = 1'b0;
         if (noisy) begin
            cmd_valid = $urandom_range(0, 1);
            cmd_rs = ~rs; cmd_read = ~rd; cmd_wdata = ~wd;
         end else begin
            cmd_valid = 1'b0;
         end
      end
      cmd_valid = 1'b0;
      if (done) begin done_cnt++; done_idx = idx; end
      check(busy_cnt == E_TOT, "R5 busy length", busy_cnt, E_TOT);
      check(first_e == E_SU + 1, "R3 strobe rise position", first_e, E_SU + 1);
      check(e_cnt == E_PW, "R4 strobe width", e_cnt, E_PW);
      check(busy_cnt - (first_e + e_cnt - 1) == E_HD, "R5 hold length",
            busy_cnt - (first_e + e_cnt - 1), E_HD);
      check(lines_ok, "R3/R2 rs rw held", lcd_rs, rs);
      check(!lcd_oe, "R6 oe low after cycle", lcd_oe, 0);
      if (rd) begin
         check(oe_ok, "R7 oe low during read", 0, 0);
         exp_late = byte1 ^ 8'h5A;
         exp_early = byte1;
         check(done_cnt == 1 && done_idx == E_SU + E_PW + 1, "R8 done pulse", done_idx, E_SU + E_PW + 1);
         check(rd_data == exp_late, "R8 late capture", rd_data, exp_late);
         check(rd_data_x == exp_early, "R10 early capture", rd_data_x, exp_early);
      end else begin
         check(oe_ok && dout_ok, "R6 write drive", lcd_dout, wd);
         check(done_cnt == 1 && done_idx == E_SU + E_PW + 1, "R9 done on write", done_idx, E_SU + E_PW + 1);
         check(rd_data == exp_late && rd_data_x == exp_early, "R9 rd_data kept", rd_data, exp_late);
      end
   endtask

   initial begin
      logic [7:0] el, ee;
      el = 8'h00; ee = 8'h00;
      void'($urandom(32'h1CD5));
      #(CLK_NS * 3);
      @(negedge clk);
      check(!busy && !lcd_e && !lcd_oe && !done && rd_data == 8'h00, "R1 reset state", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !lcd_e && !lcd_oe && !done, "R1 idle after release", busy, 0);
      // Directed: write, read, noisy write, noisy read, extreme bytes
      run_cmd(1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0, el, ee);
      run_cmd(1'b1, 1'b1, 8'h00, 8'h3C, 1'b0, el, ee);
      run_cmd(1'b1, 1'b0, 8'hFF, 8'h00, 1'b1, el, ee);
      run_cmd(1'b0, 1'b1, 8'h00, 8'h00, 1'b1, el, ee);
      run_cmd(1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, el, ee);
      for (int i = 0; i < 40; i++) begin
         run_cmd(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom),
                 8'($urandom), 1'($urandom_range(0, 1)), el, ee);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule